// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block produces the serial clock waveform that an I2C master drives onto its clock line. Each half of the waveform has its own 8-bit length setting, and both halves are stretched by one shared prescaler. A half lasts (setting + 2) prescaled ticks, with a floor of 5 ticks. One tick is (prescaler + 1) system clocks.

The master sequencer starts and stops the waveform with a run request. When run is raised, the clock starts with a low half. A one-cycle strobe marks every timed falling edge and every timed rising edge, so the sequencer can line up data changes and sampling with them. When run is dropped, the generator completes the half in progress, leaves the line released (high) and waits. The three settings can be written only while the block is disabled. Disabling the block stops the waveform at once.

Top module: `scl_timing_gen`

## Requirements
- R1: With a high setting H of 3 or more, every high half lasts exactly (H + 2) × (P + 1) system clocks, where P is the prescaler setting.
- R2: With a low setting L of 3 or more, every low half lasts exactly (L + 2) × (P + 1) system clocks, independent of the high setting.
- R3: Settings 0, 1, 2 and 3 all give a half of 5 × (P + 1) clocks. Setting 4 gives 6 × (P + 1) clocks and setting 255 gives 257 × (P + 1) clocks.
- R4: Reset clears all three settings to zero and leaves the clock output high with both strobes low. With the reset values, both halves last 5 clocks.
- R5: A write with wr_en high stores wr_data in the setting chosen by wr_sel (0 = high half, 1 = low half, 2 = prescaler, 3 = none) only when enable is low. Writes made while enable is high, and writes with wr_sel = 3, change no setting.
- R6: When run is sampled high while the generator is idle and enabled, the clock output goes low on the next cycle. fall_stb is high in exactly that first low cycle and in no other cycle.
- R7: When a timed half changes from low to high, rise_stb is high in exactly the first high cycle. No cycle ever has both strobes high.
- R8: If run is dropped during a low half, that half still lasts its full length, ends with rise_stb, and the output then stays high with no further strobes. If run is dropped during a high half and raised again before that half ends, the high half keeps its full length.
- R9: One cycle after enable is sampled low, the clock output is high and both strobes are low, and no strobe appears while disabled. When the block is enabled again with run high, it starts with a fresh low half of full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enable; low stops the waveform and unlocks the settings |
| wr_en | input | 1 | Setting write strobe |
| wr_sel | input | 2 | Setting select: 0 high half, 1 low half, 2 prescaler, 3 none |
| wr_data | input | DATA_W | Setting write value |
| run | input | 1 | Run request from the master sequencer |
| scl_out | output | 1 | Clock drive level (1 = released/high) |
| rise_stb | output | 1 | One-cycle strobe in the first high cycle of a timed rise |
| fall_stb | output | 1 | One-cycle strobe in the first low cycle of a timed fall |

## Verification
Half lengths are measured with the reset settings, with settings inside the floor (0 to 3), just above it (4), at the maximum (255), and with unequal high and low settings under prescalers 0 through 3. Together these separate a floored from a linear count, show whether the two halves use their own settings, and confirm that the prescaler multiplies the whole half rather than adding to it. Further scenarios drop run in each half, write settings while the block is enabled, and disable the block in the middle of a half. They show whether a half is cut short, whether a locked setting leaks through, and whether a restart begins with a fresh low half.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  localparam logic [1:0] SEL_HIGH = 2'd0;
  localparam logic [1:0] SEL_LOW  = 2'd1;
  localparam logic [1:0] SEL_PSC  = 2'd2;

  localparam int unsigned FLOOR_SETTING = 3;
  localparam int unsigned PHASE_OFFSET  = 2;

endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
  import scl_tg_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int PSC_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  hi_set,
  output logic [CNT_W-1:0]  lo_set,
  output logic [PSC_W-1:0]  psc_set
);

  logic unlocked_wr;
  assign unlocked_wr = wr_en && !enable;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_set  <= '0;
      lo_set  <= '0;
      psc_set <= '0;
    end else if (unlocked_wr) begin
      case (wr_sel)
        SEL_HIGH: hi_set  <= wr_data[CNT_W-1:0];
        SEL_LOW:  lo_set  <= wr_data[CNT_W-1:0];
        SEL_PSC:  psc_set <= wr_data[PSC_W-1:0];
        default:  ;
      endcase
    end
  end

  // R5: settings are frozen whenever the controller is enabled
  a_r5_hi_locked: assert property (@(posedge clk) disable iff (rst)
    enable |=> $stable(hi_set));
  a_r5_lo_locked: assert property (@(posedge clk) disable iff (rst)
    enable |=> $stable(lo_set));
  a_r5_psc_locked: assert property (@(posedge clk) disable iff (rst)
    enable |=> $stable(psc_set));

endmodule

// File: rtl/scl_tick_div.sv
module scl_tick_div #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [PSC_W-1:0] psc_set,
  output logic             tick
);

  logic [PSC_W-1:0] div_q;

  assign tick = !clr && (div_q == psc_set);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      div_q <= '0;
    end else if (div_q == psc_set) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + PSC_W'(1);
    end
  end

  // R1/R2: the divider never runs past the prescaler setting
  a_r1_div_in_range: assert property (@(posedge clk) disable iff (rst)
    !clr |-> (div_q <= psc_set));
  // R9: a clear always restarts the divider from zero
  a_r9_div_cleared: assert property (@(posedge clk) disable iff (rst)
    clr |=> (div_q == '0));

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_tg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] hi_set,
  input  logic [CNT_W-1:0] lo_set,
  output logic             div_clr,
  output logic             scl_q,
  output logic             rise_q,
  output logic             fall_q
);

  localparam int PH_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] FLOOR_V = CNT_W'(FLOOR_SETTING);

  phase_e          state_q;
  logic [PH_W-1:0] ph_q;
  logic [CNT_W-1:0] cur_set;
  logic [CNT_W-1:0] eff_set;
  logic [PH_W-1:0] cur_limit;
  logic            last_tick;

  always_comb begin
    cur_set   = (state_q == PH_HIGH) ? hi_set : lo_set;
    eff_set   = (cur_set < FLOOR_V) ? FLOOR_V : cur_set;
    cur_limit = {1'b0, eff_set} + PH_W'(PHASE_OFFSET);
    last_tick = tick && (ph_q == cur_limit - PH_W'(1));
  end

  assign div_clr = !enable || (state_q == PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state_q <= PH_IDLE;
      ph_q    <= '0;
      scl_q   <= 1'b1;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      case (state_q)
        PH_IDLE: begin
          ph_q <= '0;
          if (run) begin
            state_q <= PH_LOW;
            scl_q   <= 1'b0;
            fall_q  <= 1'b1;
          end
        end
        PH_LOW: begin
          if (last_tick) begin
            ph_q    <= '0;
            scl_q   <= 1'b1;
            rise_q  <= 1'b1;
            state_q <= run ? PH_HIGH : PH_IDLE;
          end else if (tick) begin
            ph_q <= ph_q + PH_W'(1);
          end
        end
        PH_HIGH: begin
          if (last_tick) begin
            ph_q <= '0;
            if (run) begin
              state_q <= PH_LOW;
              scl_q   <= 1'b0;
              fall_q  <= 1'b1;
            end else begin
              state_q <= PH_IDLE;
            end
          end else if (tick) begin
            ph_q <= ph_q + PH_W'(1);
          end
        end
        default: begin
          state_q <= PH_IDLE;
          scl_q   <= 1'b1;
        end
      endcase
    end
  end

  // R6: the fall strobe marks a low output and follows a sampled run
  a_r6_fall_on_low: assert property (@(posedge clk) disable iff (rst)
    fall_q |-> (!scl_q && $past(run)));
  // R7: the rise strobe marks a high output; strobes never overlap
  a_r7_rise_on_high: assert property (@(posedge clk) disable iff (rst)
    rise_q |-> scl_q);
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rise_q, fall_q}));
  // R6: every falling output edge carries the fall strobe
  a_r6_fall_marked: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_q) |-> fall_q);
  // R8: idle always holds the line released
  a_r8_idle_high: assert property (@(posedge clk) disable iff (rst)
    (state_q == PH_IDLE) |-> scl_q);
  // R1/R2: the phase counter stays below the active half length
  a_r1_phase_bound: assert property (@(posedge clk) disable iff (rst)
    (state_q != PH_IDLE) |-> (ph_q < cur_limit));
  // R9: disabling releases the line with no strobes on the next cycle
  a_r9_disable_release: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (scl_q && !rise_q && !fall_q));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_tg_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int PSC_W  = 8,
  parameter int DATA_W = (CNT_W > PSC_W) ? CNT_W : PSC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              run,
  output logic              scl_out,
  output logic              rise_stb,
  output logic              fall_stb
);

  logic [CNT_W-1:0] hi_set;
  logic [CNT_W-1:0] lo_set;
  logic [PSC_W-1:0] psc_set;
  logic             tick;
  logic             div_clr;

  scl_cfg_regs #(
    .CNT_W (CNT_W),
    .PSC_W (PSC_W),
    .DATA_W(DATA_W)
  ) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .enable (enable),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .hi_set (hi_set),
    .lo_set (lo_set),
    .psc_set(psc_set)
  );

  scl_tick_div #(
    .PSC_W(PSC_W)
  ) u_div (
    .clk    (clk),
    .rst    (rst),
    .clr    (div_clr),
    .psc_set(psc_set),
    .tick   (tick)
  );

  scl_phase_seq #(
    .CNT_W(CNT_W)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .enable (enable),
    .run    (run),
    .tick   (tick),
    .hi_set (hi_set),
    .lo_set (lo_set),
    .div_clr(div_clr),
    .scl_q  (scl_out),
    .rise_q (rise_stb),
    .fall_q (fall_stb)
  );

endmodule

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       enable;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic       run;
  logic       scl_out;
  logic       rise_stb;
  logic       fall_stb;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  scl_timing_gen dut_i (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .run     (run),
    .scl_out (scl_out),
    .rise_stb(rise_stb),
    .fall_stb(fall_stb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int hi, input int lo, input int psc);
    @(negedge clk);
    run = 1'b0; enable = 1'b0;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'(hi);
    @(negedge clk);
    wr_sel = 2'd1; wr_data = 8'(lo);
    @(negedge clk);
    wr_sel = 2'd2; wr_data = 8'(psc);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic shut_down();
    @(negedge clk);
    run = 1'b0; enable = 1'b0;
    @(negedge clk);
  endtask

  // counts low cycles from the first low sample; ends on the first high cycle
  task automatic get_low(output int n, output bit f_start, output bit r_end);
    int lim = 0;
    while (scl_out !== 1'b0 && lim < 3000) begin @(negedge clk); lim++; end
    f_start = fall_stb;
    n = 0;
    while (scl_out === 1'b0 && n < 3000) begin n++; @(negedge clk); end
    r_end = rise_stb;
  endtask

  // counts high cycles including the current one; ends on the first low cycle
  task automatic get_high(output int n, output bit f_end);
    n = 0;
    while (scl_out === 1'b1 && n < 3000) begin n++; @(negedge clk); end
    f_end = fall_stb;
  endtask

  task automatic measure(input int exp_lo, input int exp_hi, input string req);
    int nl, nh;
    bit f, r, f2;
    @(negedge clk);
    enable = 1'b1; run = 1'b1;
    get_low(nl, f, r);
    check(nl == exp_lo, {req, " low half"}, nl, exp_lo);
    check(f, "R6 fall strobe at low start", 0, 1);
    check(r, "R7 rise strobe at high start", 0, 1);
    get_high(nh, f2);
    check(nh == exp_hi, {req, " high half"}, nh, exp_hi);
    check(f2, "R6 fall strobe after high", 0, 1);
    shut_down();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(scl_out === 1'b1, "R4 scl high after reset", int'(scl_out), 1);
    check(rise_stb === 1'b0 && fall_stb === 1'b0, "R4 strobes low after reset",
          int'({rise_stb, fall_stb}), 0);
    measure(5, 5, "R4 reset settings");
  endtask

  task automatic t_start();
    cfg(6, 6, 0);
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    check(scl_out === 1'b1, "R6 idle before run", int'(scl_out), 1);
    run = 1'b1;
    @(negedge clk);
    check(scl_out === 1'b0 && fall_stb === 1'b1, "R6 one-cycle start latency",
          int'({scl_out, fall_stb}), 1);
    @(negedge clk);
    check(fall_stb === 1'b0, "R6 fall strobe single cycle", int'(fall_stb), 0);
    shut_down();
  endtask

  task automatic t_lengths();
    cfg(4, 1, 0);     measure(5, 6, "R3 settings 1 and 4");
    cfg(10, 7, 2);    measure(27, 36, "R1 R2 prescaled");
    cfg(3, 0, 3);     measure(20, 20, "R3 floor prescaled");
    cfg(255, 255, 0); measure(257, 257, "R3 maximum");
    cfg(255, 2, 1);   measure(10, 514, "R3 maximum prescaled");
  endtask

  task automatic t_lock();
    cfg(6, 6, 0);
    @(negedge clk);
    enable = 1'b1;
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'd40;
    @(negedge clk); wr_sel = 2'd1;
    @(negedge clk); wr_sel = 2'd2; wr_data = 8'd5;
    @(negedge clk); wr_en = 1'b0;
    measure(8, 8, "R5 locked writes ignored");
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd3; wr_data = 8'd99;
    @(negedge clk); wr_en = 1'b0;
    measure(8, 8, "R5 select 3 ignored");
    cfg(9, 6, 0);
    measure(8, 11, "R5 unlocked write applied");
  endtask

  task automatic t_stop_low();
    int n = 0;
    int strobes = 0;
    bit stayed = 1'b1;
    cfg(6, 6, 0);
    @(negedge clk);
    enable = 1'b1; run = 1'b1;
    @(negedge clk);
    n = 1;
    @(negedge clk); n++;
    run = 1'b0;
    @(negedge clk);
    while (scl_out === 1'b0 && n < 3000) begin n++; @(negedge clk); end
    check(n == 8, "R8 low half completes after run drop", n, 8);
    check(rise_stb === 1'b1, "R8 rise strobe at stop", int'(rise_stb), 1);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (scl_out !== 1'b1) stayed = 1'b0;
      if (rise_stb || fall_stb) strobes++;
    end
    check(stayed, "R8 line stays released", int'(stayed), 1);
    check(strobes == 0, "R8 no strobes while stopped", strobes, 0);
    shut_down();
  endtask

  task automatic t_stop_high();
    int nl, nh;
    bit f, r;
    cfg(6, 6, 0);
    @(negedge clk);
    enable = 1'b1; run = 1'b1;
    get_low(nl, f, r);
    run = 1'b0;
    @(negedge clk);
    @(negedge clk);
    run = 1'b1;
    get_high(nh, f);
    check(nh + 2 == 8, "R8 high half keeps full length", nh + 2, 8);
    check(f, "R8 waveform resumes with fall strobe", 0, 1);
    shut_down();
  endtask

  task automatic t_abort();
    int nl;
    int strobes = 0;
    bit f, r;
    bit high_ok = 1'b1;
    cfg(6, 6, 0);
    @(negedge clk);
    enable = 1'b1; run = 1'b1;
    repeat (4) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(scl_out === 1'b1 && !rise_stb && !fall_stb, "R9 immediate release",
          int'({scl_out, rise_stb, fall_stb}), 4);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (scl_out !== 1'b1) high_ok = 1'b0;
      if (rise_stb || fall_stb) strobes++;
    end
    check(high_ok && strobes == 0, "R9 quiet while disabled", strobes, 0);
    enable = 1'b1;
    get_low(nl, f, r);
    check(nl == 8, "R9 fresh low half after re-enable", nl, 8);
    check(f, "R9 restart fall strobe", 0, 1);
    shut_down();
  endtask

  initial begin
    rst = 1'b1; enable = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = 8'd0; run = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_start();
    t_lengths();
    t_lock();
    t_stop_low();
    t_stop_high();
    t_abort();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule